// File: doc/BRIEF.md
# Address-Filtered Bus Transaction Re-Timer

This block sits between a fast multi-master backplane and a slave that runs far slower than the backplane expects. Each transaction seen on the fast side is captured into internal registers: address, address modifier, transfer size, direction and write data. The registers hold fewer than 100 bits. The held transaction is then replayed to the slow slave with every strobe edge pushed out far enough to meet the slave's minimum delays. Nearly every timing relationship the slave depends on is a minimum delay, so adding cycles on replay is enough to satisfy it.

The slave holds one transaction at a time. A further transaction is taken only once the slave has acknowledged the current one and both replayed strobes have dropped again. A mode input selects how transactions are chosen. In filtered mode, only transactions that fall inside the slave's base/mask address window are forwarded. In pass-all mode, every transaction is forwarded. Traffic for other boards does not wait for this slave, so such traffic that arrives while a replay is running simply finishes on the bus and is dropped. A transaction aimed at this slave is never lost: the block holds the bus off with a stall until the slave is free.

Top module: `xact_retimer`

## Requirements
- R1: While reset is asserted and on release, `sl_as`, `sl_ds`, `bus_stall` and `bus_done` are low and `bus_rdata` is zero.
- R2: A bus address is a hit when `((bus_addr ^ cfg_base) & cfg_mask) == 0`. A mask of zero makes every address a hit.
- R3: With `cfg_pass_all` low, a transaction that is not a hit causes no replay, no stall and no change to the held fields.
- R4: With `cfg_pass_all` high, a transaction presented while the block is idle is accepted whether or not it hits.
- R5: The held fields appear on `sl_*` in the cycle after the accepting edge. After the fields have been shown for `cfg_setup`+1 cycles, `sl_as` rises. After `sl_as` has been high for `cfg_dsdly`+1 cycles, `sl_ds` rises.
- R6: From acceptance until completion, the held address, modifier, size, direction and write data on `sl_*` do not change.
- R7: When `sl_ack` is seen high while `sl_ds` is asserted, `sl_rdata` is captured and both strobes drop in the next cycle. When `sl_ack` is then seen low, `bus_done` pulses high for one cycle with the captured data on `bus_rdata`, and the block is idle again.
- R8: A transaction that is not a hit and arrives while a replay is in progress is dropped without a stall, and the held fields are unchanged.
- R9: A hit presented while a replay is in progress raises `bus_stall` combinationally for as long as the block stays busy. It is accepted in the first idle cycle.
- R10: `sl_ds` only rises in a cycle where `sl_as` was already high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pass_all | input | 1 | 1: forward every transaction; 0: forward only hits |
| cfg_base | input | 32 | Address window base |
| cfg_mask | input | 32 | Address bits that take part in the compare |
| cfg_setup | input | CNT_W | Address-to-strobe setup count (cycles minus one) |
| cfg_dsdly | input | CNT_W | Address-strobe-to-data-strobe count (cycles minus one) |
| bus_valid | input | 1 | A transaction is on the fast bus |
| bus_addr | input | 32 | Transaction address |
| bus_am | input | 6 | Address modifier |
| bus_size | input | 2 | Transfer size code |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 32 | Write data |
| bus_stall | output | 1 | Holds off a hit while the slave is busy |
| bus_done | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read data captured from the slave |
| sl_addr | output | 32 | Replayed address |
| sl_am | output | 6 | Replayed address modifier |
| sl_size | output | 2 | Replayed size code |
| sl_write | output | 1 | Replayed direction |
| sl_wdata | output | 32 | Replayed write data |
| sl_as | output | 1 | Replayed address strobe, active high |
| sl_ds | output | 1 | Replayed data strobe, active high |
| sl_ack | input | 1 | Slave acknowledge |
| sl_rdata | input | 32 | Slave read data |

## Verification
The bench runs delay counts of zero, where an off-by-one in either counter would make a strobe rise too soon or too late. It sends traffic for other boards in the middle of a replay: a design that latched that traffic would corrupt the held address, and a design that stalled it would hang the bus. It also presents a hit while the block is busy, which would be lost if the design dropped it instead of stalling. It exercises release ordering, where a design that pulsed done on the acknowledge itself rather than after the strobes dropped would finish one cycle early. A zero mask is used to show that every address then counts as a hit.

// File: rtl/rt_pkg.sv
package rt_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int AM_W   = 6;
    localparam int SIZE_W = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [AM_W-1:0]   am;
        logic [SIZE_W-1:0] size;
        logic              write;
        logic [DATA_W-1:0] wdata;
    } xact_t;

    localparam int XACT_W = $bits(xact_t);

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_ASTB  = 3'd2,
        PH_DSTB  = 3'd3,
        PH_REL   = 3'd4
    } phase_e;
endpackage

// File: rtl/rt_addr_match.sv
module rt_addr_match
    import rt_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    output logic              hit
);
    logic [ADDR_W-1:0] diff;

    genvar gi;
    generate
        for (gi = 0; gi < ADDR_W; gi++) begin : g_bit
            assign diff[gi] = (addr[gi] ^ base[gi]) & mask[gi];
        end
    endgenerate

    assign hit = ~|diff;
endmodule

// File: rtl/rt_hold_reg.sv
module rt_hold_reg
    import rt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  xact_t xact_in,
    output xact_t xact_out
);
    xact_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (load) begin
            hold_d = xact_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign xact_out = hold_q;
endmodule

// File: rtl/rt_replay_seq.sv
module rt_replay_seq
    import rt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_dsdly,
    input  logic              sl_ack,
    input  logic [DATA_W-1:0] sl_rdata,
    output logic              idle,
    output logic              as_o,
    output logic              ds_o,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.ph  = PH_SETUP;
                    s_d.cnt = '0;
                end
            end
            PH_SETUP: begin
                if (s_q.cnt >= cfg_setup) begin
                    s_d.ph  = PH_ASTB;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_ASTB: begin
                if (s_q.cnt >= cfg_dsdly) begin
                    s_d.ph  = PH_DSTB;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_DSTB: begin
                if (sl_ack) begin
                    s_d.ph    = PH_REL;
                    s_d.rdata = sl_rdata;
                end
            end
            PH_REL: begin
                if (!sl_ack) begin
                    s_d.ph   = PH_IDLE;
                    s_d.done = 1'b1;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, cnt: '0, rdata: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign idle  = (s_q.ph == PH_IDLE);
    assign as_o  = (s_q.ph == PH_ASTB) || (s_q.ph == PH_DSTB);
    assign ds_o  = (s_q.ph == PH_DSTB);
    assign done  = s_q.done;
    assign rdata = s_q.rdata;

    // R10: data strobe rises only after the address strobe was up
    a_r10_as_before_ds: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ds_o) |-> $past(as_o));

    // R7: completion is a single-cycle pulse with strobes already down
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!as_o && !ds_o && !sl_ack));

    // R7: strobes fall the cycle after an acknowledge during the data phase
    a_r7_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_o && sl_ack) |=> (!as_o && !ds_o));
endmodule

// File: rtl/xact_retimer.sv
module xact_retimer
    import rt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pass_all,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_mask,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_dsdly,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [AM_W-1:0]   bus_am,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic              bus_write,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_stall,
    output logic              bus_done,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] sl_addr,
    output logic [AM_W-1:0]   sl_am,
    output logic [SIZE_W-1:0] sl_size,
    output logic              sl_write,
    output logic [DATA_W-1:0] sl_wdata,
    output logic              sl_as,
    output logic              sl_ds,
    input  logic              sl_ack,
    input  logic [DATA_W-1:0] sl_rdata
);
    logic  hit;
    logic  seq_idle;
    logic  accept;
    xact_t bus_x;
    xact_t held_x;

    rt_addr_match u_match (
        .addr (bus_addr),
        .base (cfg_base),
        .mask (cfg_mask),
        .hit  (hit)
    );

    assign bus_x  = '{addr: bus_addr, am: bus_am, size: bus_size,
                      write: bus_write, wdata: bus_wdata};
    assign accept = bus_valid && seq_idle && (hit || cfg_pass_all);
    assign bus_stall = bus_valid && hit && !seq_idle;

    rt_hold_reg u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .xact_in  (bus_x),
        .xact_out (held_x)
    );

    rt_replay_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .cfg_setup (cfg_setup),
        .cfg_dsdly (cfg_dsdly),
        .sl_ack    (sl_ack),
        .sl_rdata  (sl_rdata),
        .idle      (seq_idle),
        .as_o      (sl_as),
        .ds_o      (sl_ds),
        .done      (bus_done),
        .rdata     (bus_rdata)
    );

    assign sl_addr  = held_x.addr;
    assign sl_am    = held_x.am;
    assign sl_size  = held_x.size;
    assign sl_write = held_x.write;
    assign sl_wdata = held_x.wdata;

    // R9: an accepted transaction makes the sequencer busy on the next cycle
    a_r9_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !seq_idle);

    // R6, R8: held fields stay put while a replay is in progress
    a_r6_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_idle && $past(!seq_idle)) |-> $stable(held_x));

    // R5: the address strobe never rises in the cycle right after acceptance
    a_r5_setup_gap: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !sl_as);
endmodule

// File: tb/xact_retimer_bench.sv
`timescale 1ns/1ps
module xact_retimer_bench;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_pass_all = 1'b0;
    logic [31:0] cfg_base = 32'h4000_0000;
    logic [31:0] cfg_mask = 32'hFFFF_0000;
    logic [CW-1:0] cfg_setup = 8'd2;
    logic [CW-1:0] cfg_dsdly = 8'd1;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [5:0]  bus_am = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_write = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_stall, bus_done;
    logic [31:0] bus_rdata;
    logic [31:0] sl_addr, sl_wdata;
    logic [5:0]  sl_am;
    logic [1:0]  sl_size;
    logic        sl_write, sl_as, sl_ds;
    logic        sl_ack = 1'b0;
    logic [31:0] sl_rdata = '0;

    int checks = 0;
    int errors = 0;
    int as_rises = 0;
    logic as_prev = 1'b0;

    always #2 clk = ~clk;

    xact_retimer #(.CNT_W(CW)) u_xact_retimer (
        .clk(clk), .rst_n(rst_n), .cfg_pass_all(cfg_pass_all),
        .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_setup(cfg_setup),
        .cfg_dsdly(cfg_dsdly), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_am(bus_am), .bus_size(bus_size), .bus_write(bus_write),
        .bus_wdata(bus_wdata), .bus_stall(bus_stall), .bus_done(bus_done),
        .bus_rdata(bus_rdata), .sl_addr(sl_addr), .sl_am(sl_am),
        .sl_size(sl_size), .sl_write(sl_write), .sl_wdata(sl_wdata),
        .sl_as(sl_as), .sl_ds(sl_ds), .sl_ack(sl_ack), .sl_rdata(sl_rdata)
    );

    // ---------------- behavioural reference ----------------
    int          m_ph = 0;   // 0 idle,1 addr shown,2 as,3 as+ds,4 released
    int          m_cnt = 0;
    logic [31:0] m_addr = '0, m_wdata = '0, m_rd = '0;
    logic [5:0]  m_am = '0;
    logic [1:0]  m_size = '0;
    logic        m_wr = 1'b0, m_done = 1'b0;

    function automatic bit is_hit(input logic [31:0] a);
        return ((a ^ cfg_base) & cfg_mask) == 32'd0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_done = 0; m_rd = '0;
            m_addr = '0; m_wdata = '0; m_am = '0; m_size = '0; m_wr = 0;
        end else begin
            m_done = 0;
            if (m_ph == 0) begin
                if (bus_valid && (is_hit(bus_addr) || cfg_pass_all)) begin
                    m_addr = bus_addr; m_am = bus_am; m_size = bus_size;
                    m_wr = bus_write; m_wdata = bus_wdata;
                    m_ph = 1; m_cnt = 0;
                end
            end else if (m_ph == 1) begin
                if (m_cnt >= int'(cfg_setup)) begin m_ph = 2; m_cnt = 0; end
                else m_cnt++;
            end else if (m_ph == 2) begin
                if (m_cnt >= int'(cfg_dsdly)) begin m_ph = 3; m_cnt = 0; end
                else m_cnt++;
            end else if (m_ph == 3) begin
                if (sl_ack) begin m_rd = sl_rdata; m_ph = 4; end
            end else begin
                if (!sl_ack) begin m_ph = 0; m_done = 1; end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, 1 ns before the next rising edge
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (rst_n) begin
                chk(sl_as == (m_ph == 2 || m_ph == 3), "R5 sl_as", 32'(sl_as), 32'(m_ph == 2 || m_ph == 3));
                chk(sl_ds == (m_ph == 3), "R5 sl_ds", 32'(sl_ds), 32'(m_ph == 3));
                chk(bus_stall == (bus_valid && is_hit(bus_addr) && m_ph != 0),
                    "R9 bus_stall", 32'(bus_stall), 32'(bus_valid && is_hit(bus_addr) && m_ph != 0));
                chk(bus_done == m_done, "R7 bus_done", 32'(bus_done), 32'(m_done));
                if (m_done) chk(bus_rdata == m_rd, "R7 bus_rdata", bus_rdata, m_rd);
                if (m_ph != 0) begin
                    chk(sl_addr == m_addr, "R6 sl_addr", sl_addr, m_addr);
                    chk({sl_am, sl_size, sl_write} == {m_am, m_size, m_wr},
                        "R6 sl_am/size/write", 32'({sl_am, sl_size, sl_write}), 32'({m_am, m_size, m_wr}));
                    chk(sl_wdata == m_wdata, "R6 sl_wdata", sl_wdata, m_wdata);
                end
                if (sl_as && !as_prev) as_rises++;
                as_prev = sl_as;
            end
        end
    end

    // slow slave: acknowledges two cycles into the data strobe
    initial begin
        int lat = 0;
        forever begin
            @(negedge clk);
            if (sl_ds && !sl_ack) begin
                lat++;
                if (lat >= 2) begin sl_ack = 1'b1; sl_rdata = ~sl_addr; lat = 0; end
            end else if (!sl_ds) begin
                sl_ack = 1'b0;
                lat = 0;
            end
        end
    end

    task automatic put(input logic [31:0] a, input logic [5:0] am, input logic [1:0] sz,
                       input logic wr, input logic [31:0] wd, input bit waits);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_am = am; bus_size = sz;
        bus_write = wr; bus_wdata = wd;
        #1;
        while (waits && bus_stall) begin @(negedge clk); #1; end
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while ((m_ph != 0 || bus_done) && n < 200) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    initial begin
        int base_rises;
        repeat (3) @(negedge clk);
        #1;
        chk(!sl_as && !sl_ds && !bus_stall && !bus_done && bus_rdata == 0,
            "R1 reset outputs", {sl_as, sl_ds, bus_stall, bus_done}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!sl_as && !sl_ds && !bus_done, "R1 after release", {sl_as, sl_ds, bus_done}, 0);

        // filtered hit, read
        put(32'h4000_0010, 6'h09, 2'd2, 1'b0, 32'h0, 1'b1);
        wait_idle();
        chk(bus_rdata == ~32'h4000_0010, "R7 read data returned", bus_rdata, ~32'h4000_0010);

        // filtered miss: no replay
        base_rises = as_rises;
        put(32'h5000_0020, 6'h0D, 2'd1, 1'b1, 32'hAAAA_5555, 1'b0);
        repeat (12) @(negedge clk);
        chk(as_rises == base_rises, "R3 miss ignored (as rises)", as_rises, base_rises);
        chk(sl_addr == 32'h4000_0010, "R3 held addr unchanged", sl_addr, 32'h4000_0010);

        // pass-all miss accepted, then traffic during replay
        cfg_pass_all = 1'b1;
        put(32'h7777_0040, 6'h3D, 2'd3, 1'b1, 32'h1234_5678, 1'b0);
        @(negedge clk);
        chk(sl_addr == 32'h7777_0040, "R4 pass-all miss forwarded", sl_addr, 32'h7777_0040);
        put(32'h6000_0000, 6'h01, 2'd0, 1'b0, 32'h0, 1'b0);
        chk(sl_addr == 32'h7777_0040, "R8 busy miss dropped", sl_addr, 32'h7777_0040);
        put(32'h4000_0080, 6'h0A, 2'd2, 1'b1, 32'hCAFE_F00D, 1'b1);
        @(negedge clk);
        chk(sl_addr == 32'h4000_0080, "R9 stalled hit later accepted", sl_addr, 32'h4000_0080);
        wait_idle();

        // zero delays, zero mask
        cfg_pass_all = 1'b0;
        cfg_setup = 8'd0; cfg_dsdly = 8'd0; cfg_mask = 32'h0;
        base_rises = as_rises;
        put(32'h9ABC_DEF0, 6'h2F, 2'd1, 1'b0, 32'h0, 1'b1);
        wait_idle();
        chk(as_rises == base_rises + 1, "R2 zero mask hits any address", as_rises, base_rises + 1);
        chk(bus_rdata == ~32'h9ABC_DEF0, "R5 zero-delay replay data", bus_rdata, ~32'h9ABC_DEF0);

        // longer delays, back-to-back hits
        cfg_setup = 8'd5; cfg_dsdly = 8'd3; cfg_mask = 32'hFFFF_F000;
        put(32'h4000_0100, 6'h09, 2'd2, 1'b1, 32'h0BAD_BEEF, 1'b1);
        put(32'h4000_0200, 6'h09, 2'd2, 1'b0, 32'h0, 1'b1);
        wait_idle();
        chk(bus_rdata == ~32'h4000_0200, "R9 second hit completed", bus_rdata, ~32'h4000_0200);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule